// File: doc/BRIEF.md
# Split-Screen Scan Address Generator

This block produces, for every displayed scan line of a raster, the byte address in display memory where that line's pixel data begins. It also produces the sub-byte pixel shift, 0 to 7, used for fine horizontal scrolling. Software programs a frame base address, a row pitch, a pan value and a split line through a byte-wide register write port. The raster timing logic drives a frame-start strobe at the top of each frame and a line-start strobe at the beginning of each following line.

The base address and the pan value are double-buffered. A write lands in a pending register and reaches the outputs only at the next frame start, so a frame never shows a mix of old and new settings. When the line counter equals the programmed split line, the next line restarts at address zero. All remaining lines of that frame form a fixed lower region whose origin cannot be moved. A mode bit can force the pixel shift to zero inside that region, so the lower region stays still while the upper region scrolls.

Top module: `scan_addr_gen`

## Requirements
- R1: After reset, line_addr, pix_shift, split_active and every register are zero.
- R2: The base address is written as a high byte (wr_sel 0) and a low byte (wr_sel 1). It reaches line_addr one cycle after the next frame_start. A write made during a frame does not alter that frame's line addresses.
- R3: Each line_start (without frame_start) advances line_addr by twice the pitch register (wr_sel 2, a count of 16-bit words).
- R4: The split line is 10 bits wide, assembled from three registers. Bits 7..0 come from wr_sel 3. Bit 8 comes from bit 4 of wr_sel 4. Bit 9 comes from bit 6 of wr_sel 5.
- R5: On a line_start while the line counter equals the split line, line_addr becomes 0 and split_active becomes 1. Later lines advance from 0 by the pitch.
- R6: A split line the frame never reaches produces no split: split_active stays 0 and line addresses keep advancing.
- R7: The pan value (wr_sel 6, bits 2..0) reaches pix_shift only one cycle after the next frame_start.
- R8: With the suppress bit (wr_sel 7, bit 5) set, pix_shift is 0 while split_active is 1. With the bit clear, the split region uses the same pan as the top region.
- R9: status bit 3 follows vsync. All other status bits are 0.
- R10: frame_start resets the line counter and clears split_active. It takes priority over a line_start in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 8 | Register write data |
| frame_start | input | 1 | Top-of-frame strobe |
| line_start | input | 1 | Next-line strobe |
| vsync | input | 1 | Vertical sync level |
| line_addr | output | 16 | Byte address of the current line |
| pix_shift | output | 3 | Sub-byte pixel shift |
| split_active | output | 1 | Current line is in the split region |
| status | output | 8 | Status byte, vsync at bit 3 |

## Verification
The bench writes the base address and the pan value in the middle of a frame. A design without double-buffering would change the address or the shift before the next frame starts. It runs a split line of 0x305, so the two upper bits must come from the right bit positions; a wrong bit position would place the split hundreds of lines off, or never trigger it. It checks the first two lines of the split region, to catch an off-by-one in the restart and a region that restarts somewhere other than zero. It also toggles the suppress bit while inside the split region, and drives frame_start and line_start in the same cycle to check which one wins.

// File: rtl/scan_pkg.sv
package scan_pkg;
   localparam int REG_SEL_W = 3;
   localparam logic [REG_SEL_W-1:0] SEL_BASE_HI = 3'd0;
   localparam logic [REG_SEL_W-1:0] SEL_BASE_LO = 3'd1;
   localparam logic [REG_SEL_W-1:0] SEL_PITCH   = 3'd2;
   localparam logic [REG_SEL_W-1:0] SEL_SPLIT_L = 3'd3;
   localparam logic [REG_SEL_W-1:0] SEL_SPLIT_8 = 3'd4;
   localparam logic [REG_SEL_W-1:0] SEL_SPLIT_9 = 3'd5;
   localparam logic [REG_SEL_W-1:0] SEL_PAN     = 3'd6;
   localparam logic [REG_SEL_W-1:0] SEL_MODE    = 3'd7;
   localparam int SPLIT8_BIT   = 4;
   localparam int SPLIT9_BIT   = 6;
   localparam int SUPPRESS_BIT = 5;
   localparam int VSYNC_BIT    = 3;
endpackage

// File: rtl/scan_regs.sv
module scan_regs
   import scan_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int LINE_W       = 10,
   parameter int PAN_W        = 3,
   parameter bit HAS_SUPPRESS = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [REG_SEL_W-1:0] wr_sel,
   input  logic [7:0]           wr_data,
   output logic [ADDR_W-1:0]    base_pend,
   output logic [7:0]           pitch_q,
   output logic [LINE_W-1:0]    split_line,
   output logic [PAN_W-1:0]     pan_pend,
   output logic                 suppress
);
   logic [7:0] base_hi, base_lo, split_lo;
   logic       split_b8, split_b9, mode_sup;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_hi  <= '0;
         base_lo  <= '0;
         pitch_q  <= '0;
         split_lo <= '0;
         split_b8 <= 1'b0;
         split_b9 <= 1'b0;
         pan_pend <= '0;
         mode_sup <= 1'b0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_BASE_HI: base_hi  <= wr_data;
            SEL_BASE_LO: base_lo  <= wr_data;
            SEL_PITCH:   pitch_q  <= wr_data;
            SEL_SPLIT_L: split_lo <= wr_data;
            SEL_SPLIT_8: split_b8 <= wr_data[SPLIT8_BIT];
            SEL_SPLIT_9: split_b9 <= wr_data[SPLIT9_BIT];
            SEL_PAN:     pan_pend <= wr_data[PAN_W-1:0];
            SEL_MODE:    mode_sup <= wr_data[SUPPRESS_BIT];
            default: ;
         endcase
      end
   end

   assign base_pend  = {{(ADDR_W-16){1'b0}}, base_hi, base_lo};
   assign split_line = {{(LINE_W-10){1'b0}}, split_b9, split_b8, split_lo};

   generate
      if (HAS_SUPPRESS) begin : g_sup
         assign suppress = mode_sup;
      end else begin : g_nosup
         assign suppress = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/scan_line_track.sv
module scan_line_track #(
   parameter int LINE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              line_start,
   input  logic [LINE_W-1:0] split_line,
   output logic [LINE_W-1:0] line_cnt,
   output logic              in_split,
   output logic              restart
);
   localparam logic [LINE_W-1:0] CNT_MAX = '1;

   assign restart = line_start && !frame_start && !in_split &&
                    (line_cnt == split_line);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_cnt <= '0;
         in_split <= 1'b0;
      end else if (frame_start) begin
         line_cnt <= '0;
         in_split <= 1'b0;
      end else if (line_start) begin
         if (line_cnt != CNT_MAX) line_cnt <= line_cnt + 1'b1;
         if (restart) in_split <= 1'b1;
      end
   end
endmodule

// File: rtl/scan_row_addr.sv
module scan_row_addr #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              line_start,
   input  logic              restart,
   input  logic [ADDR_W-1:0] base_pend,
   input  logic [7:0]        pitch_q,
   output logic [ADDR_W-1:0] row_addr
);
   logic [ADDR_W-1:0] step;
   assign step = {{(ADDR_W-9){1'b0}}, pitch_q, 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           row_addr <= '0;
      else if (frame_start) row_addr <= base_pend;
      else if (restart)     row_addr <= '0;
      else if (line_start)  row_addr <= row_addr + step;
   end
endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen
   import scan_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int LINE_W       = 10,
   parameter int PAN_W        = 3,
   parameter bit HAS_SUPPRESS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [7:0]        wr_data,
   input  logic              frame_start,
   input  logic              line_start,
   input  logic              vsync,
   output logic [ADDR_W-1:0] line_addr,
   output logic [PAN_W-1:0]  pix_shift,
   output logic              split_active,
   output logic [7:0]        status
);
   generate
      if (ADDR_W < 16) begin : g_chk_addr
         $error("ADDR_W must be at least 16");
      end
      if (LINE_W < 10) begin : g_chk_line
         $error("LINE_W must be at least 10");
      end
      if (PAN_W != 3) begin : g_chk_pan
         $error("PAN_W must be 3");
      end
   endgenerate

   logic [ADDR_W-1:0] base_pend;
   logic [7:0]        pitch_q;
   logic [LINE_W-1:0] split_line;
   logic [PAN_W-1:0]  pan_pend;
   logic [PAN_W-1:0]  pan_eff;
   logic              suppress;
   logic [LINE_W-1:0] line_cnt;
   logic              restart;

   scan_regs #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .PAN_W(PAN_W),
               .HAS_SUPPRESS(HAS_SUPPRESS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .base_pend(base_pend), .pitch_q(pitch_q),
      .split_line(split_line), .pan_pend(pan_pend), .suppress(suppress)
   );

   scan_line_track #(.LINE_W(LINE_W)) u_track (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .line_start(line_start), .split_line(split_line),
      .line_cnt(line_cnt), .in_split(split_active), .restart(restart)
   );

   scan_row_addr #(.ADDR_W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .line_start(line_start), .restart(restart), .base_pend(base_pend),
      .pitch_q(pitch_q), .row_addr(line_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           pan_eff <= '0;
      else if (frame_start) pan_eff <= pan_pend;
   end

   assign pix_shift = (split_active && suppress) ? '0 : pan_eff;

   always_comb begin
      status = '0;
      status[VSYNC_BIT] = vsync;
   end
endmodule

// File: rtl/scan_addr_gen_chk.sv
module scan_addr_gen_chk #(
   parameter int ADDR_W = 16,
   parameter int LINE_W = 10,
   parameter int PAN_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_start,
   input logic              line_start,
   input logic [ADDR_W-1:0] line_addr,
   input logic [PAN_W-1:0]  pix_shift,
   input logic              split_active,
   input logic [ADDR_W-1:0] base_pend,
   input logic [7:0]        pitch_q,
   input logic [LINE_W-1:0] split_line,
   input logic [LINE_W-1:0] line_cnt,
   input logic [PAN_W-1:0]  pan_eff,
   input logic              suppress
);
   logic [ADDR_W-1:0] step_c;
   assign step_c = {{(ADDR_W-9){1'b0}}, pitch_q, 1'b0};

   AST_FRAME_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (line_addr == $past(base_pend)) && !split_active); // R2

   AST_LINE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && !frame_start && (split_active || line_cnt != split_line))
      |=> line_addr == $past(line_addr + step_c)); // R3

   AST_SPLIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && !frame_start && !split_active && line_cnt == split_line)
      |=> (line_addr == '0) && split_active); // R5

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_start && !line_start) |=> $stable(line_addr)); // R3

   AST_PAN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(pan_eff)); // R7

   AST_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
      (split_active && suppress) |-> pix_shift == '0); // R8

   AST_SPLIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (line_cnt == '0)); // R10
endmodule

bind scan_addr_gen scan_addr_gen_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W),
                                      .PAN_W(PAN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
   .line_start(line_start), .line_addr(line_addr), .pix_shift(pix_shift),
   .split_active(split_active), .base_pend(base_pend), .pitch_q(pitch_q),
   .split_line(split_line), .line_cnt(line_cnt), .pan_eff(pan_eff),
   .suppress(suppress)
);

// File: tb/scan_addr_gen_tb.sv
module scan_addr_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [7:0]  wr_data = '0;
   logic        frame_start = 1'b0;
   logic        line_start = 1'b0;
   logic        vsync = 1'b0;
   logic [15:0] line_addr;
   logic [2:0]  pix_shift;
   logic        split_active;
   logic [7:0]  status;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   scan_addr_gen u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .frame_start(frame_start), .line_start(line_start),
      .vsync(vsync), .line_addr(line_addr), .pix_shift(pix_shift),
      .split_active(split_active), .status(status)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic frame();
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
   endtask

   task automatic lines(input int n);
      for (int i = 0; i < n; i++) begin
         line_start = 1'b1;
         @(negedge clk);
         line_start = 1'b0;
      end
   endtask

   function automatic logic [15:0] exp_addr(input logic [15:0] b, input int p, input int n);
      return 16'(int'(b) + n * 2 * p);
   endfunction

   task automatic t_reset();
      check(line_addr == 0, "R1 addr", line_addr, 0);
      check(pix_shift == 0, "R1 shift", pix_shift, 0);
      check(split_active == 0, "R1 split", split_active, 0);
      frame();
      check(line_addr == 0, "R1 base reg", line_addr, 0);
   endtask

   task automatic t_status();
      vsync = 1'b1; #1;
      check(status == 8'h08, "R9 high", status, 8'h08);
      vsync = 1'b0; #1;
      check(status == 8'h00, "R9 low", status, 0);
   endtask

   task automatic t_advance();
      wr(3'd2, 8'h40); wr(3'd0, 8'h12); wr(3'd1, 8'h34);
      wr(3'd3, 8'hFF); wr(3'd4, 8'h10); wr(3'd5, 8'h40); // split 1023
      frame();
      check(line_addr == 16'h1234, "R2 base", line_addr, 16'h1234);
      lines(1);
      check(line_addr == 16'h12B4, "R3 line1", line_addr, 16'h12B4);
      lines(2);
      check(line_addr == 16'h13B4, "R3 line3", line_addr, 16'h13B4);
      wr(3'd0, 8'h20); wr(3'd1, 8'h00);
      lines(1);
      check(line_addr == 16'h1434, "R2 deferred", line_addr, 16'h1434);
      frame();
      check(line_addr == 16'h2000, "R2 next frame", line_addr, 16'h2000);
   endtask

   task automatic t_split_low();
      wr(3'd3, 8'h03); wr(3'd4, 8'hEF); wr(3'd5, 8'hBF); // split 3
      frame(); lines(3);
      check(line_addr == exp_addr(16'h2000, 8'h40, 3), "R5 before", line_addr, exp_addr(16'h2000, 8'h40, 3));
      check(split_active == 0, "R5 before flag", split_active, 0);
      lines(1);
      check(line_addr == 0, "R5 restart", line_addr, 0);
      check(split_active == 1, "R5 flag", split_active, 1);
      lines(1);
      check(line_addr == 16'h0080, "R5 after", line_addr, 16'h0080);
      frame();
      check(split_active == 0, "R10 clear", split_active, 0);
   endtask

   task automatic t_split_high();
      wr(3'd3, 8'h05); wr(3'd4, 8'h10); wr(3'd5, 8'h40); // split 0x305
      frame(); lines(773);
      check(line_addr == exp_addr(16'h2000, 8'h40, 773), "R4 at 0x305", line_addr, exp_addr(16'h2000, 8'h40, 773));
      check(split_active == 0, "R4 no early split", split_active, 0);
      lines(1);
      check(line_addr == 0 && split_active, "R4 split 0x305", line_addr, 0);
   endtask

   task automatic t_no_split();
      wr(3'd3, 8'hBC); wr(3'd4, 8'h00); wr(3'd5, 8'h40); // split 700
      frame(); lines(500);
      check(split_active == 0, "R6 flag", split_active, 0);
      check(line_addr == exp_addr(16'h2000, 8'h40, 500), "R6 addr", line_addr, exp_addr(16'h2000, 8'h40, 500));
   endtask

   task automatic t_pan();
      wr(3'd3, 8'h02); wr(3'd4, 8'h00); wr(3'd5, 8'h00); // split 2
      frame();
      wr(3'd6, 8'hFD); // pan 5
      check(pix_shift == 0, "R7 held", pix_shift, 0);
      frame();
      check(pix_shift == 5, "R7 applied", pix_shift, 5);
      lines(3);
      check(split_active == 1 && pix_shift == 5, "R8 no suppress", pix_shift, 5);
      wr(3'd7, 8'h20);
      check(pix_shift == 0, "R8 suppressed", pix_shift, 0);
      frame();
      check(pix_shift == 5, "R8 top region", pix_shift, 5);
      wr(3'd7, 8'h00);
   endtask

   task automatic t_priority();
      frame(); lines(3);
      frame_start = 1'b1; line_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0; line_start = 1'b0;
      check(line_addr == 16'h2000, "R10 addr", line_addr, 16'h2000);
      check(split_active == 0, "R10 flag", split_active, 0);
      lines(3);
      check(line_addr == 0 && split_active, "R10 count restarted", line_addr, 0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_status();
            t_advance();
            t_split_low();
            t_split_high();
            t_no_split();
            t_pan();
            t_priority();
            done = 1'b1;
         end
         begin
            repeat (20000) @(negedge clk);
            if (!done) check(1'b0, "watchdog", 0, 1);
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule